// File: doc/BRIEF.md
# HCI UART with RTS/CTS flow control

This block is a full-duplex asynchronous serial port for a host controller link. It carries four wires: serial out, serial in, an active-low request-to-send output and an active-low clear-to-send input. Each direction has a 480-byte FIFO so that bursts at multi-megabit rates can be absorbed. On its parallel side, the transmit FIFO is filled through a valid/ready push and the receive FIFO is emptied through a valid/ready pop.

A single configuration write sets four things: the bit period, given as a count of reference ticks; which of two reference tick streams clocks the port (a 24 MHz or a 48 MHz enable); and the receive high-water and low-water marks. After reset the port runs at 115200 baud from the 24 MHz reference, with a divisor of 208. The 48 MHz reference reaches 4 Mbaud with a divisor of 12. At the low end, 9600 baud needs a divisor of 2500 from the 24 MHz reference.

Transmission waits for clear-to-send. The receiver raises request-to-send when its FIFO fills up to the high-water mark. It lowers request-to-send again once the FIFO has drained below the low-water mark.

Top module: `hci_uart`

## Requirements
- R1: After reset, uartTxd and uartRtsN are 0-free idle (uartTxd=1, uartRtsN=0), rxValid=0, frameErr=0, txReady=1, and the port runs at 208 ticks of the 24 MHz reference per bit.
- R2: Each character is a start bit of 0, then 8 data bits with the least significant bit first, then a stop bit of 1. Each bit lasts bitDiv ticks of the selected reference.
- R3: A cfgWe pulse loads cfgDiv as the bit period in reference ticks. It also loads cfgRefSel, where 0 selects ref24Tick and 1 selects ref48Tick.
- R4: The receiver detects the falling edge of the start bit, confirms the start bit half a bit later, and samples each following bit one bit period apart. Bytes reach rxData in the order they arrived.
- R5: Each FIFO holds 480 bytes. txReady is 1 while the transmit FIFO holds fewer than 480 bytes and 0 when it is full.
- R6: No character starts while uartCtsN is 1. After uartCtsN falls, a pending character starts within 24 bit periods.
- R7: If uartCtsN rises before the middle of a stop bit, the next queued character does not start until uartCtsN falls again.
- R8: uartRtsN goes to 1 when the receive FIFO count reaches the high-water mark. It returns to 0 only when the count is below the low-water mark, and it holds its value for counts in between.
- R9: A stop bit sampled as 0 sets frameErr, which stays at 1 until reset. The byte in that frame is discarded.
- R10: Frames whose bit period is up to 4% shorter or longer than the configured period are received correctly.
- R11: When a received byte brings the FIFO count up to the high-water mark, uartRtsN is 1 no later than 2 bit periods after the middle of that byte's stop bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ref24Tick | input | 1 | One-cycle enable at the 24 MHz reference rate |
| ref48Tick | input | 1 | One-cycle enable at the 48 MHz reference rate |
| cfgWe | input | 1 | Configuration write strobe |
| cfgRefSel | input | 1 | Reference select: 0 = 24 MHz, 1 = 48 MHz |
| cfgDiv | input | DIV_W | Reference ticks per bit |
| cfgHiMark | input | CNT_W | Receive count at which uartRtsN is raised |
| cfgLoMark | input | CNT_W | uartRtsN is lowered when the receive count is below this value |
| txData | input | 8 | Byte to transmit |
| txValid | input | 1 | Push txData into the transmit FIFO |
| txReady | output | 1 | Transmit FIFO has room |
| rxData | output | 8 | Oldest received byte |
| rxValid | output | 1 | Receive FIFO not empty |
| rxReady | input | 1 | Pop the oldest received byte |
| uartTxd | output | 1 | Serial data out |
| uartRxd | input | 1 | Serial data in |
| uartRtsN | output | 1 | Active-low request-to-send |
| uartCtsN | input | 1 | Active-low clear-to-send |
| frameErr | output | 1 | Sticky framing-error flag |

## Verification
The assertions assume three things about the inputs:
- configuration writes arrive only while both shifters are idle;
- cfgDiv is at least 4;
- the low-water mark does not exceed the high-water mark.

The stimulus keeps to all three. It writes the configuration only after each character has fully finished, uses divisors of 12 or more, and sets the marks to pairs such as 3 and 2. Serial input frames are driven on the falling clock edge and respect the configured bit period to within 4%. The framing-error case holds the line high for a full bit period after the bad stop bit, so the line is idle again before the next frame.

// File: rtl/hciu_pkg.sv
package hciu_pkg;
  localparam int DIV_W_DEF  = 12;
  localparam int DEPTH_DEF  = 480;
  localparam int DEF_DIV    = 208;   // 24 MHz / 115200
  localparam int DEF_HI     = 448;
  localparam int DEF_LO     = 32;

  typedef struct packed {
    logic refTick;     // selected reference enable
    logic txAllowed;   // synchronised clear-to-send
  } hciu_strobe_t;
endpackage

// File: rtl/hciu_fifo.sv
module hciu_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 480,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [WIDTH-1:0] pushData,
  input  logic             pop,
  output logic [WIDTH-1:0] popData,
  output logic [CNT_W-1:0] count
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop;

  assign doPush  = push && (count != CNT_W'(DEPTH));
  assign doPop   = pop && (count != '0);
  assign popData = mem[rdPtr];

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (doPop)  rdPtr <= nextPtr(rdPtr);
      case ({doPush, doPop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_count_bound_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_push_grows_R5: assert property (@(posedge clk) disable iff (!rstN)
    (push && !pop && count < CNT_W'(DEPTH)) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/hciu_ctrl.sv
module hciu_ctrl
  import hciu_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF,
  parameter int CNT_W = 9,
  parameter int RST_DIV = DEF_DIV,
  parameter int RST_HI = DEF_HI,
  parameter int RST_LO = DEF_LO
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ref24Tick,
  input  logic             ref48Tick,
  input  logic             cfgWe,
  input  logic             cfgRefSel,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [CNT_W-1:0] cfgHiMark,
  input  logic [CNT_W-1:0] cfgLoMark,
  input  logic             uartCtsN,
  input  logic [CNT_W-1:0] rxCount,
  output hciu_strobe_t     strobe,
  output logic [DIV_W-1:0] bitDiv,
  output logic             uartRtsN
);
  logic             refSel;
  logic [CNT_W-1:0] hiMark, loMark;
  logic             ctsMeta, ctsSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refSel <= 1'b0;
      bitDiv <= DIV_W'(RST_DIV);
      hiMark <= CNT_W'(RST_HI);
      loMark <= CNT_W'(RST_LO);
    end else if (cfgWe) begin
      refSel <= cfgRefSel;
      bitDiv <= cfgDiv;
      hiMark <= cfgHiMark;
      loMark <= cfgLoMark;
    end
  end

  // two-flop synchroniser, reset to "blocked"
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctsMeta <= 1'b1;
      ctsSync <= 1'b1;
    end else begin
      ctsMeta <= uartCtsN;
      ctsSync <= ctsMeta;
    end
  end

  // hysteresis between the two marks
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  uartRtsN <= 1'b0;
    else if (rxCount >= hiMark) uartRtsN <= 1'b1;
    else if (rxCount < loMark)  uartRtsN <= 1'b0;
  end

  always_comb begin
    strobe.refTick   = refSel ? ref48Tick : ref24Tick;
    strobe.txAllowed = !ctsSync;
  end

  assert_rts_rise_R8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(uartRtsN) |-> $past(rxCount) >= $past(hiMark));
  assert_rts_fall_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(uartRtsN) |-> $past(rxCount) < $past(loMark));
  assert_cfg_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    cfgWe |=> (bitDiv == $past(cfgDiv)));
endmodule

// File: rtl/hciu_datapath.sv
module hciu_datapath
  import hciu_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  hciu_strobe_t     strobe,
  input  logic [DIV_W-1:0] bitDiv,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             uartTxd,
  input  logic             uartRxd,
  output logic             frameErr,
  output logic [CNT_W-1:0] rxCount
);
  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP, RX_WAITHI} rx_state_t;

  // ---------------- transmit ----------------
  logic [CNT_W-1:0] txCount;
  logic [7:0]       txHead;
  logic             txBusy, txLoad;
  logic [9:0]       txShift;
  logic [3:0]       txBit;
  logic [DIV_W-1:0] txCnt;

  assign txReady = (txCount != CNT_W'(DEPTH));
  assign txLoad  = !txBusy && (txCount != '0) && strobe.txAllowed && strobe.refTick;

  hciu_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_txFifo (
    .clk(clk), .rstN(rstN), .push(txValid), .pushData(txData),
    .pop(txLoad), .popData(txHead), .count(txCount));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txBusy  <= 1'b0;
      txShift <= '1;
      txBit   <= '0;
      txCnt   <= '0;
    end else if (txLoad) begin
      txBusy  <= 1'b1;
      txShift <= {1'b1, txHead, 1'b0};
      txBit   <= '0;
      txCnt   <= '0;
    end else if (txBusy && strobe.refTick) begin
      if (txCnt == bitDiv - 1'b1) begin
        txCnt <= '0;
        if (txBit == 4'd9) txBusy <= 1'b0;
        else begin
          txBit   <= txBit + 1'b1;
          txShift <= {1'b1, txShift[9:1]};
        end
      end else txCnt <= txCnt + 1'b1;
    end
  end

  assign uartTxd = txBusy ? txShift[0] : 1'b1;

  // ---------------- receive ----------------
  rx_state_t        rxState;
  logic             rxMeta, rxSync, rxPush;
  logic [DIV_W-1:0] rxCnt;
  logic [2:0]       rxBit;
  logic [7:0]       rxShift;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxMeta <= 1'b1;
      rxSync <= 1'b1;
    end else begin
      rxMeta <= uartRxd;
      rxSync <= rxMeta;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rxState  <= RX_IDLE;
      rxCnt    <= '0;
      rxBit    <= '0;
      rxShift  <= '0;
      rxPush   <= 1'b0;
      frameErr <= 1'b0;
    end else begin
      rxPush <= 1'b0;
      case (rxState)
        RX_IDLE: if (strobe.refTick && !rxSync) begin
          rxState <= RX_START;
          rxCnt   <= '0;
        end
        RX_START: if (strobe.refTick) begin
          if (rxCnt == (bitDiv >> 1)) begin
            rxState <= rxSync ? RX_IDLE : RX_DATA;
            rxCnt   <= '0;
            rxBit   <= '0;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_DATA: if (strobe.refTick) begin
          if (rxCnt == bitDiv - 1'b1) begin
            rxCnt   <= '0;
            rxShift <= {rxSync, rxShift[7:1]};
            rxBit   <= rxBit + 1'b1;
            if (rxBit == 3'd7) rxState <= RX_STOP;
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_STOP: if (strobe.refTick) begin
          if (rxCnt == bitDiv - 1'b1) begin
            if (rxSync) begin
              rxPush  <= 1'b1;
              rxState <= RX_IDLE;
            end else begin
              frameErr <= 1'b1;
              rxState  <= RX_WAITHI;
            end
          end else rxCnt <= rxCnt + 1'b1;
        end
        RX_WAITHI: if (rxSync) rxState <= RX_IDLE;
        default: rxState <= RX_IDLE;
      endcase
    end
  end

  hciu_fifo #(.WIDTH(8), .DEPTH(DEPTH)) u_rxFifo (
    .clk(clk), .rstN(rstN), .push(rxPush), .pushData(rxShift),
    .pop(rxReady), .popData(rxData), .count(rxCount));

  assign rxValid = (rxCount != '0);

  assert_cts_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> $past(strobe.txAllowed));
  assert_stop_level_R2: assert property (@(posedge clk) disable iff (!rstN)
    (txBusy && txBit == 4'd9) |-> uartTxd);
  assert_ferr_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    frameErr |=> frameErr);
  assert_discard_R9: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_STOP && strobe.refTick && rxCnt == bitDiv - 1'b1 && !rxSync) |=> !rxPush);
endmodule

// File: rtl/hci_uart.sv
module hci_uart
  import hciu_pkg::*;
#(
  parameter int DIV_W = DIV_W_DEF,
  parameter int DEPTH = DEPTH_DEF,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             ref24Tick,
  input  logic             ref48Tick,
  input  logic             cfgWe,
  input  logic             cfgRefSel,
  input  logic [DIV_W-1:0] cfgDiv,
  input  logic [CNT_W-1:0] cfgHiMark,
  input  logic [CNT_W-1:0] cfgLoMark,
  input  logic [7:0]       txData,
  input  logic             txValid,
  output logic             txReady,
  output logic [7:0]       rxData,
  output logic             rxValid,
  input  logic             rxReady,
  output logic             uartTxd,
  input  logic             uartRxd,
  output logic             uartRtsN,
  input  logic             uartCtsN,
  output logic             frameErr
);
  hciu_strobe_t     strobe;
  logic [DIV_W-1:0] bitDiv;
  logic [CNT_W-1:0] rxCount;

  hciu_ctrl #(.DIV_W(DIV_W), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .ref24Tick(ref24Tick), .ref48Tick(ref48Tick),
    .cfgWe(cfgWe), .cfgRefSel(cfgRefSel), .cfgDiv(cfgDiv),
    .cfgHiMark(cfgHiMark), .cfgLoMark(cfgLoMark), .uartCtsN(uartCtsN),
    .rxCount(rxCount), .strobe(strobe), .bitDiv(bitDiv), .uartRtsN(uartRtsN));

  hciu_datapath #(.DIV_W(DIV_W), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .bitDiv(bitDiv),
    .txData(txData), .txValid(txValid), .txReady(txReady),
    .rxData(rxData), .rxValid(rxValid), .rxReady(rxReady),
    .uartTxd(uartTxd), .uartRxd(uartRxd), .frameErr(frameErr), .rxCount(rxCount));
endmodule

// File: tb/hci_uart_tb.sv
module hci_uart_tb;
  localparam int DIV_W = 12;
  localparam int DEPTH = 480;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 0, rstN = 0;
  logic ref24Tick = 0, ref48Tick = 1;
  logic cfgWe = 0, cfgRefSel = 0;
  logic [DIV_W-1:0] cfgDiv = '0;
  logic [CNT_W-1:0] cfgHiMark = '0, cfgLoMark = '0;
  logic [7:0] txData = '0;
  logic txValid = 0, txReady, rxValid, rxReady = 0, frameErr;
  logic [7:0] rxData;
  logic uartTxd, uartRxd = 1, uartRtsN, uartCtsN = 1;
  int checks = 0, errors = 0;
  bit finished = 0;

  hci_uart u_dut (.*);

  always #10 clk = ~clk;                       // 50 MHz
  always @(negedge clk) ref24Tick <= !ref24Tick; // half-rate enable

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 0; txValid = 0; rxReady = 0; uartRxd = 1; uartCtsN = 1;
    repeat (4) @(negedge clk);
    rstN = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic cfg(input bit sel, input int div, input int hi, input int lo);
    @(negedge clk);
    cfgRefSel = sel; cfgDiv = DIV_W'(div);
    cfgHiMark = CNT_W'(hi); cfgLoMark = CNT_W'(lo); cfgWe = 1;
    @(negedge clk);
    cfgWe = 0;
  endtask

  task automatic pushByte(input logic [7:0] b);
    @(negedge clk);
    txData = b; txValid = 1;
    @(negedge clk);
    txValid = 0;
  endtask

  // wait for a start bit, then sample each bit at its middle; returns at stop middle
  task automatic txCapture(input int T, input logic [7:0] exp, input int limit, input string tag);
    int waited = 0;
    logic [7:0] got = '0;
    logic stopV;
    while (uartTxd !== 1'b0 && waited < limit) begin
      @(negedge clk); waited++;
    end
    if (waited >= limit) begin
      chk(0, {tag, " no start bit"}, waited, limit);
      return;
    end
    repeat (T / 2) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      repeat (T) @(negedge clk);
      got[i] = uartTxd;
    end
    repeat (T) @(negedge clk);
    stopV = uartTxd;
    chk(got == exp && stopV == 1'b1, tag, {got, 7'd0, stopV}, {exp, 8'd1});
  endtask

  task automatic rxSend(input logic [7:0] b, input int T, input logic stopV);
    @(negedge clk);
    uartRxd = 0; repeat (T) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uartRxd = b[i]; repeat (T) @(negedge clk);
    end
    uartRxd = stopV; repeat (T) @(negedge clk);
    uartRxd = 1; repeat (T) @(negedge clk);
  endtask

  task automatic popExpect(input logic [7:0] exp, input string tag);
    @(negedge clk);
    chk(rxValid && rxData == exp, tag, {rxValid, rxData}, {1'b1, exp});
    rxReady = 1;
    @(negedge clk);
    rxReady = 0;
  endtask

  task automatic testReset();
    doReset();
    chk(uartTxd == 1, "R1 txd idle", uartTxd, 1);
    chk(uartRtsN == 0, "R1 rts ready", uartRtsN, 0);
    chk(rxValid == 0, "R1 rx empty", rxValid, 0);
    chk(frameErr == 0, "R1 no frame error", frameErr, 0);
    chk(txReady == 1, "R1 tx ready", txReady, 1);
  endtask

  task automatic testDefaultBaud();   // R1 R2: 208 ticks of half-rate ref = 416 clocks
    uartCtsN = 0;
    pushByte(8'hA5);
    txCapture(416, 8'hA5, 2000, "R1 R2 default baud byte");
    repeat (600) @(negedge clk);
  endtask

  task automatic testBaudCfg();       // R3
    cfg(1, 12, 3, 2);
    pushByte(8'h3C);
    txCapture(12, 8'h3C, 200, "R3 48MHz div12");
    repeat (30) @(negedge clk);
    cfg(0, 12, 3, 2);
    pushByte(8'hC3);
    txCapture(24, 8'hC3, 200, "R3 24MHz div12");
    repeat (60) @(negedge clk);
  endtask

  task automatic testRxOrder();       // R4
    cfg(1, 12, 400, 300);
    rxSend(8'h12, 12, 1);
    rxSend(8'hFE, 12, 1);
    rxSend(8'h00, 12, 1);
    popExpect(8'h12, "R4 first byte");
    popExpect(8'hFE, "R4 second byte");
    popExpect(8'h00, "R4 third byte");
  endtask

  task automatic testFrameErr();      // R9
    rxSend(8'h5A, 12, 0);
    repeat (5) @(negedge clk);
    chk(frameErr == 1, "R9 frame error set", frameErr, 1);
    chk(rxValid == 0, "R9 bad byte discarded", rxValid, 0);
    rxSend(8'h77, 12, 1);
    chk(frameErr == 1, "R9 frame error sticky", frameErr, 1);
    popExpect(8'h77, "R9 next good byte");
  endtask

  task automatic testTolerance();     // R10
    cfg(1, 100, 400, 300);
    rxSend(8'h96, 96, 1);
    rxSend(8'h69, 104, 1);
    popExpect(8'h96, "R10 fast sender");
    popExpect(8'h69, "R10 slow sender");
  endtask

  task automatic testCtsGate();       // R6
    int lowSeen = 0;
    cfg(1, 12, 400, 300);
    uartCtsN = 1;
    pushByte(8'h81);
    for (int i = 0; i < 240; i++) begin
      @(negedge clk);
      if (uartTxd == 0) lowSeen++;
    end
    chk(lowSeen == 0, "R6 held while cts high", lowSeen, 0);
    uartCtsN = 0;
    txCapture(12, 8'h81, 24 * 12, "R6 start within 24 bits");
    repeat (20) @(negedge clk);
  endtask

  task automatic testCtsStop();       // R7
    int lowSeen = 0;
    uartCtsN = 1;
    pushByte(8'h11);
    pushByte(8'h22);
    uartCtsN = 0;
    txCapture(12, 8'h11, 400, "R7 first byte");
    uartCtsN = 1;                     // raised at stop-bit middle
    for (int i = 0; i < 360; i++) begin
      @(negedge clk);
      if (uartTxd == 0) lowSeen++;
    end
    chk(lowSeen == 0, "R7 next byte held", lowSeen, 0);
    uartCtsN = 0;
    txCapture(12, 8'h22, 400, "R7 second byte after release");
    repeat (20) @(negedge clk);
  endtask

  task automatic testRts();           // R8 R11
    cfg(1, 12, 3, 2);
    rxSend(8'h01, 12, 1);
    rxSend(8'h02, 12, 1);
    chk(uartRtsN == 0, "R8 below high mark", uartRtsN, 0);
    // third byte: check one and a half bits after stop middle
    @(negedge clk);
    uartRxd = 0; repeat (12) @(negedge clk);
    for (int i = 0; i < 8; i++) begin
      uartRxd = 1'(8'h03 >> i); repeat (12) @(negedge clk);
    end
    uartRxd = 1; repeat (12 + 12) @(negedge clk);
    chk(uartRtsN == 1, "R11 rts raised within 2 bits", uartRtsN, 1);
    popExpect(8'h01, "R8 pop 1");
    repeat (3) @(negedge clk);
    chk(uartRtsN == 1, "R8 hysteresis hold", uartRtsN, 1);
    popExpect(8'h02, "R8 pop 2");
    repeat (3) @(negedge clk);
    chk(uartRtsN == 0, "R8 lowered below low mark", uartRtsN, 0);
    popExpect(8'h03, "R8 pop 3");
  endtask

  task automatic testTxFull();        // R5
    int notReady = 0;
    doReset();
    cfg(1, 12, 400, 300);
    uartCtsN = 1;
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      if (!txReady) notReady++;
      txData = 8'(i); txValid = 1;
    end
    @(negedge clk);
    txValid = 0;
    chk(notReady == 0, "R5 ready up to 480", notReady, 0);
    @(negedge clk);
    chk(txReady == 0, "R5 full at 480", txReady, 0);
    uartCtsN = 0;
    txCapture(12, 8'h00, 400, "R5 oldest byte first");
    @(negedge clk);
    chk(txReady == 1, "R5 room after drain", txReady, 1);
  endtask

  initial begin
    testReset();
    testDefaultBaud();
    testBaudCfg();
    testRxOrder();
    testFrameErr();
    testTolerance();
    testCtsGate();
    testCtsStop();
    testRts();
    testTxFull();
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule